// File: doc/BRIEF.md
# Cascaded Timestamp Counter

A free-running timestamp of twice the stage width is built from two counter channels of equal width. The low channel counts ticks from a prescaler that divides the system clock. It drives a waveform output that goes high each time its count rolls over to zero and goes low at half scale. A link select routes that waveform into the external clock input of the high channel. The high channel detects the rising transition synchronously and advances one clock cycle later.

A restart command clears the prescaler, both channels and the waveform in the same cycle. A read strobe captures both halves in one cycle into a snapshot register. The capture folds in a carry that is still pending in the high channel, so a read never combines halves from opposite sides of a rollover and software needs no retry loop. When a parameter selects single-channel operation, one channel of full timestamp width does the counting and the link select has no effect.

Top module: `tsc_timestamp`

## Requirements
- R1: While rst_ni is low, snap_o is all zeros and snap_valid_o and wave_o are 0.
- R2: The low stage advances by one on every PRESCALE-th clock cycle after reset or restart. The first increment comes PRESCALE cycles after the restart edge. With the link held on since the last restart, a snapshot equals the number of prescaled ticks counted so far, modulo 2^(2*STAGE_W).
- R3: wave_o goes to 1 when the low stage counts from all ones to 0. It goes to 0 when the low stage counts to 2^(STAGE_W-1). Reset and restart clear it.
- R4: With link_en_i at 1, the high stage increments once for each rising transition of wave_o. The increment lands one cycle after the transition. Turning the link on while wave_o is 1 counts as a rising transition.
- R5: With link_en_i at 0, the high stage holds its value and the low stage keeps counting.
- R6: sync_i sampled at 1 on an edge clears the prescaler phase, both stages and wave_o at that edge. A snapshot strobed on the same edge captures the value from before the clear.
- R7: snap_i sampled at 1 on an edge loads snap_o with {high, low} as of that edge. snap_valid_o is 1 in the following cycle only. snap_o holds between strobes.
- R8: A snapshot taken in the cycle between a low-stage rollover and the high-stage increment already shows the incremented high half.
- R9: With SINGLE_CHAN=1, one counter of width 2*STAGE_W counts the prescaled ticks. wave_o rises when that counter reaches 0 and falls at 2^(2*STAGE_W-1). link_en_i has no effect.
- R10: The timestamp wraps from all ones to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Restart all stages in the same cycle |
| link_en_i | input | 1 | 1 routes the low-stage waveform into the high-stage clock input |
| snap_i | input | 1 | Read strobe, captures the timestamp |
| snap_o | output | 2*STAGE_W | Captured timestamp, high half in the upper bits |
| snap_valid_o | output | 1 | One-cycle flag after a capture |
| wave_o | output | 1 | Low-stage rollover waveform |

## Verification
The bench builds two instances with 6-bit stages, so a whole timestamp of 12 bits wraps within a few thousand cycles. The first instance is chained with a prescale of 3, which puts a low-stage rollover every 192 cycles. That makes many carry-pending snapshots and several full wraps reachable. The second uses single-channel mode with a prescale of 2, so it wraps its 12-bit counter in 8192 cycles, and toggling the link select shows that the select has no effect there.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [0:0] {
    SRC_INT = 1'b0,
    SRC_EXT = 1'b1
  } clk_src_e;
endpackage

// File: rtl/tsc_prescaler.sv
module tsc_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, sync_i};
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      assign tick_o = (cnt_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (sync_i)  cnt_q <= '0;
        else if (tick_o)  cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tsc_channel.sv
module tsc_channel
  import tsc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_i,
  input  clk_src_e     src_i,
  input  logic         int_tick_i,
  input  logic         ext_i,
  output logic [W-1:0] cnt_o,
  output logic         wave_o,
  output logic         ext_rise_o
);
  localparam logic [W-1:0] CMP_SET = '0;
  localparam logic [W-1:0] CMP_CLR = {1'b1, {(W-1){1'b0}}};

  logic         ext_q;
  logic         step;
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         wave_q;

  assign ext_rise_o = ext_i & ~ext_q;
  assign step       = (src_i == SRC_INT) ? int_tick_i : ext_rise_o;
  assign cnt_nxt    = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ext_q <= 1'b0;
    else if (sync_i) ext_q <= 1'b0;
    else             ext_q <= ext_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (sync_i) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_nxt;
  end

  // waveform set on rollover to zero, cleared at half scale
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wave_q <= 1'b0;
    else if (sync_i)                      wave_q <= 1'b0;
    else if (step && cnt_nxt == CMP_SET)  wave_q <= 1'b1;
    else if (step && cnt_nxt == CMP_CLR)  wave_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign wave_o = wave_q;
endmodule

// File: rtl/tsc_link.sv
module tsc_link (
  input  logic link_en_i,
  input  logic wave_i,
  output logic xc_o
);
  assign xc_o = link_en_i & wave_i;
endmodule

// File: rtl/tsc_timestamp.sv
module tsc_timestamp
  import tsc_pkg::*;
#(
  parameter int STAGE_W     = 16,
  parameter int PRESCALE    = 8,
  parameter bit SINGLE_CHAN = 1'b0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sync_i,
  input  logic                   link_en_i,
  input  logic                   snap_i,
  output logic [2*STAGE_W-1:0]   snap_o,
  output logic                   snap_valid_o,
  output logic                   wave_o
);
  localparam int TS_W = 2 * STAGE_W;

  logic               tick;
  logic [STAGE_W-1:0] lo_cnt, hi_cnt;
  logic               pending;
  logic [TS_W-1:0]    snap_q;
  logic               valid_q;

  tsc_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .tick_o (tick)
  );

  generate
    if (SINGLE_CHAN) begin : g_single
      logic [TS_W-1:0] cnt;
      logic            unused_rise;
      logic            unused_link;
      assign unused_link = link_en_i;
      tsc_channel #(.W(TS_W)) u_ch0 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_i     (sync_i),
        .src_i      (SRC_INT),
        .int_tick_i (tick),
        .ext_i      (1'b0),
        .cnt_o      (cnt),
        .wave_o     (wave_o),
        .ext_rise_o (unused_rise)
      );
      assign lo_cnt  = cnt[STAGE_W-1:0];
      assign hi_cnt  = cnt[TS_W-1:STAGE_W];
      assign pending = 1'b0;
    end else begin : g_chain
      logic lo_wave, xc1;
      logic unused_rise0, unused_wave1;
      tsc_channel #(.W(STAGE_W)) u_ch0 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_i     (sync_i),
        .src_i      (SRC_INT),
        .int_tick_i (tick),
        .ext_i      (1'b0),
        .cnt_o      (lo_cnt),
        .wave_o     (lo_wave),
        .ext_rise_o (unused_rise0)
      );
      tsc_link u_link (
        .link_en_i (link_en_i),
        .wave_i    (lo_wave),
        .xc_o      (xc1)
      );
      tsc_channel #(.W(STAGE_W)) u_ch1 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_i     (sync_i),
        .src_i      (SRC_EXT),
        .int_tick_i (1'b0),
        .ext_i      (xc1),
        .cnt_o      (hi_cnt),
        .wave_o     (unused_wave1),
        .ext_rise_o (pending)
      );
      assign wave_o = lo_wave;
    end
  endgenerate

  // carry still pending in the high stage is folded into the capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= snap_i;
      if (snap_i) snap_q <= {hi_cnt + STAGE_W'(pending), lo_cnt};
    end
  end

  assign snap_o       = snap_q;
  assign snap_valid_o = valid_q;
endmodule

// File: rtl/tsc_timestamp_chk.sv
module tsc_timestamp_chk #(
  parameter int STAGE_W     = 16,
  parameter bit SINGLE_CHAN = 1'b0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_i,
  input logic               snap_i,
  input logic               snap_valid_o,
  input logic               wave_o,
  input logic               tick,
  input logic [STAGE_W-1:0] lo_cnt,
  input logic [STAGE_W-1:0] hi_cnt,
  input logic               pending
);
  AST_SNAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> snap_valid_o); // R7
  AST_SNAP_FLAG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> !snap_valid_o); // R7
  AST_SYNC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (lo_cnt == '0 && hi_cnt == '0 && !wave_o)); // R6
  AST_LOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_i && !tick) |=> $stable(lo_cnt)); // R2
  AST_WAVE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wave_o) |-> (lo_cnt == '0)); // R3

  generate
    if (!SINGLE_CHAN) begin : g_chain_chk
      AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sync_i && !pending) |=> $stable(hi_cnt)); // R4
    end
  endgenerate
endmodule

bind tsc_timestamp tsc_timestamp_chk #(
  .STAGE_W     (STAGE_W),
  .SINGLE_CHAN (SINGLE_CHAN)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sync_i       (sync_i),
  .snap_i       (snap_i),
  .snap_valid_o (snap_valid_o),
  .wave_o       (wave_o),
  .tick         (tick),
  .lo_cnt       (lo_cnt),
  .hi_cnt       (hi_cnt),
  .pending      (pending)
);

// File: tb/test_tsc_timestamp.sv
module test_tsc_timestamp;
  localparam int SW = 6;
  localparam int TW = 2 * SW;
  localparam int PA = 3;
  localparam int PB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync = 1'b0, link = 1'b1, snap = 1'b0;
  logic [TW-1:0] snap_a, snap_b;
  logic vld_a, vld_b, wave_a, wave_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tsc_timestamp #(.STAGE_W(SW), .PRESCALE(PA), .SINGLE_CHAN(1'b0)) i_tsc_timestamp (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .link_en_i(link), .snap_i(snap),
    .snap_o(snap_a), .snap_valid_o(vld_a), .wave_o(wave_a));

  tsc_timestamp #(.STAGE_W(SW), .PRESCALE(PB), .SINGLE_CHAN(1'b1)) i_tsc_single (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .link_en_i(link), .snap_i(snap),
    .snap_o(snap_b), .snap_valid_o(vld_b), .wave_o(wave_b));

  // chained model
  int pc_a;
  logic [SW-1:0] lo_a, hi_a;
  bit wave_m_a, prev_a, link_clean;
  logic [TW-1:0] flat_a, exp_a, exp_flat_a, last_a;
  bit exp_v, exp_flat_ok;
  string tag_a;
  bit just_synced;
  // single model
  int pc_b;
  logic [TW-1:0] cnt_b, exp_b;
  bit wave_m_b;

  task automatic check(input bit ok, input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pc_a = 0; lo_a = '0; hi_a = '0; wave_m_a = 0; prev_a = 0; flat_a = '0;
      exp_a = '0; exp_v = 0; link_clean = 1; just_synced = 0; exp_flat_ok = 0;
      pc_b = 0; cnt_b = '0; wave_m_b = 0; exp_b = '0; last_a = '0;
    end else begin
      bit xc, pend;
      xc = link & wave_m_a;
      pend = xc & ~prev_a;
      exp_v = snap;
      if (snap) begin
        exp_a = {hi_a + SW'(pend), lo_a};
        exp_flat_a = flat_a;
        exp_flat_ok = link_clean;
        if (pend) tag_a = "R8";
        else if (just_synced) tag_a = "R6";
        else if (!link) tag_a = "R5";
        else if (exp_a < last_a) tag_a = "R10";
        else if (exp_a[TW-1:SW] != last_a[TW-1:SW]) tag_a = "R4";
        else tag_a = "R7";
        last_a = exp_a;
        exp_b = cnt_b;
      end
      if (!link) link_clean = 0;
      if (sync) begin
        pc_a = 0; lo_a = '0; hi_a = '0; wave_m_a = 0; prev_a = 0; flat_a = '0;
        pc_b = 0; cnt_b = '0; wave_m_b = 0; link_clean = link; just_synced = 1;
        last_a = '0;
      end else begin
        just_synced = 0;
        if (pend) hi_a = hi_a + 1'b1;
        if (xc & ~prev_a & !(pend)) link_clean = 0;
        prev_a = xc;
        if (pc_a == PA - 1) begin
          pc_a = 0; lo_a = lo_a + 1'b1; flat_a = flat_a + 1'b1;
          if (lo_a == '0) wave_m_a = 1;
          else if (lo_a == SW'(1 << (SW - 1))) wave_m_a = 0;
        end else pc_a++;
        if (pc_b == PB - 1) begin
          pc_b = 0; cnt_b = cnt_b + 1'b1;
          if (cnt_b == '0) wave_m_b = 1;
          else if (cnt_b == TW'(1 << (TW - 1))) wave_m_b = 0;
        end else pc_b++;
      end
    end
  end

  // turning the link on while the waveform is high adds a count the flat model lacks
  always @(posedge clk) if (rst_n && !sync && !prev_a && link && wave_m_a && !$past(link)) link_clean = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(vld_a === exp_v && vld_b === exp_v, "R7", TW'({vld_a, vld_b}), TW'({exp_v, exp_v}));
      check(wave_a === wave_m_a, "R3", TW'(wave_a), TW'(wave_m_a));
      check(wave_b === wave_m_b, "R9", TW'(wave_b), TW'(wave_m_b));
      check(snap_a === exp_a, tag_a, snap_a, exp_a);
      check(snap_b === exp_b, "R9", snap_b, exp_b);
      if (exp_v && exp_flat_ok) check(snap_a === exp_flat_a, "R2", snap_a, exp_flat_a);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  task automatic cycles(input int n, input int snap_pct, input int sync_per, input int link_per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      snap = (($urandom % 100) < snap_pct);
      sync = (sync_per > 0) && (($urandom % sync_per) == 0);
      if (link_per > 0 && ($urandom % link_per) == 0) link = ~link;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tag_a = "R7";
    repeat (4) @(negedge clk);
    // R1 reset state
    check(snap_a === '0 && snap_b === '0, "R1", snap_a | snap_b, '0);
    check(!vld_a && !vld_b && !wave_a && !wave_b, "R1", TW'({vld_a, vld_b, wave_a, wave_b}), '0);
    rst_n = 1'b1;
    // long run: full wraps of both instances (R10, R9)
    cycles(14000, 25, 0, 0);
    // dense reads across many rollovers (R8, R4)
    cycles(800, 100, 0, 0);
    // link off: high half frozen (R5)
    @(negedge clk); #1 link = 1'b0;
    cycles(900, 30, 0, 0);
    @(negedge clk); #1 link = 1'b1;
    cycles(300, 30, 0, 0);
    // restart with simultaneous strobe and strobe right after (R6)
    @(negedge clk); #1 sync = 1'b1; snap = 1'b1;
    @(negedge clk); #1 sync = 1'b0; snap = 1'b1;
    @(negedge clk); #1 snap = 1'b0;
    cycles(400, 20, 0, 0);
    // mixed random traffic
    cycles(8000, 33, 2500, 1800);
    @(negedge clk); #1 snap = 1'b0; sync = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule